// File: doc/BRIEF.md
# PWM Output Steering Unit

The unit takes one pulse-width-modulated waveform and routes it onto any combination of four output pins. Each pin has an enable bit in an 8-bit steering register: when the bit is set the pin carries the modulated waveform, and when it is clear the pin carries an ordinary port-latch value. One waveform can appear on one, two, three or all four pins at once. A 2-bit polarity field chooses the active level of the steered pins. Steering applies only while the upstream modulator reports its single-output configuration. In any other configuration every pin shows its port value.

A write to the steering register can take effect at once, or it can be parked in a shadow copy and applied at the next period-start strobe. The sync bit in the written data chooses which. An auto-shutdown input drives only the steered pins to their inactive level. It stays in force until a period start arrives with the shutdown input low. All pin outputs are registered, so a pin never shows a partial change within a clock cycle.

Top module: `pwm_steer`

## Requirements
- R1: After reset, the read value is 0x01 (pin A enabled, sync 0, pins B to D on port data) and every pin output is 0.
- R2: With single-output mode on, a pin whose active enable bit is 1 carries the PWM input (after polarity), and a pin whose bit is 0 carries its port input. Register bit 0 enables pin A, bit 1 pin B, bit 2 pin C and bit 3 pin D. Any subset may be enabled at once.
- R3: Polarity bit 1 inverts the steered level of pins A and C, and polarity bit 0 inverts pins B and D. A value of 0 means active-high.
- R4: A write with bit 4 (sync) = 0 changes the active enables at the clock edge that takes the write. It also cancels any pending deferred write.
- R5: A write with bit 4 = 1 leaves the active enables unchanged. The written enables go to a shadow copy and become active at the first later edge where the period-start input is high. A strobe at the same edge as the write does not apply that write.
- R6: A read returns the last written bits 4:0, not the active enables. Bits 7:5 read as 0, and writing them has no effect.
- R7: While shutdown is in force, each steered pin drives its inactive level: the polarity inversion bit of that pin. Pins on port data keep following the port inputs.
- R8: Shutdown takes hold at the first edge where the shutdown input is high. It is released only at an edge where the period-start input is high and the shutdown input is low.
- R9: With single-output mode off, every pin carries its port input, whatever the steering register holds.
- R10: Pin outputs are registered: each pin shows the value that was selected from the inputs and state present before the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Steering register write strobe |
| wr_data_i | input | 8 | Write data: bits 3:0 pin enables (A to D), bit 4 sync |
| rd_data_o | output | 8 | Written register value, upper bits zero |
| single_mode_i | input | 1 | Modulator is in single-output mode |
| pol_i | input | 2 | Polarity field |
| pwm_i | input | 1 | Modulated waveform |
| period_start_i | input | 1 | One-cycle strobe at the start of each PWM period |
| shutdown_i | input | 1 | Auto-shutdown request |
| port_i | input | 4 | Port-latch values for pins A to D |
| pin_o | output | 4 | Pin outputs A to D |

## Verification
The riskiest coincidence is a deferred steering write and a period-start strobe in the same cycle. This includes the case where an older deferred write is still pending, which must be applied at that strobe while the new one waits. A second is a shutdown release: a strobe that falls while shutdown is still asserted must not release it, while a steering update applied at that same strobe must take effect underneath the shutdown. The bench drives both cases on purpose. A behavioural model compares every pin and the read value on every cycle, so any error at the wrong edge is reported at the cycle it happens.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

  localparam int unsigned PIN_CNT = 4;
  localparam int unsigned REG_BITS = 8;

  typedef enum logic {
    UPD_NOW    = 1'b0,
    UPD_PERIOD = 1'b1
  } upd_mode_e;

  typedef enum logic {
    SD_RUN  = 1'b0,
    SD_HOLD = 1'b1
  } sd_state_e;

  // even pins follow pol[1], odd pins follow pol[0]
  function automatic logic pin_invert(input int unsigned idx, input logic [1:0] pol);
    return (idx % 2 == 0) ? pol[1] : pol[0];
  endfunction

endpackage

// File: rtl/pwm_steer_regs.sv
module pwm_steer_regs
  import pwm_steer_pkg::*;
#(
  parameter int unsigned NPINS  = PIN_CNT,
  parameter int unsigned REG_W  = REG_BITS,
  parameter logic [NPINS-1:0] RST_EN = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             period_start_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [NPINS-1:0] act_o,
  output logic             pend_o
);
  localparam int unsigned SYNC_BIT = NPINS;

  logic [NPINS-1:0] en_q, shadow_q, act_q;
  logic             sync_q, pend_q;
  upd_mode_e        wr_mode;

  assign wr_mode = upd_mode_e'(wr_data_i[SYNC_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= RST_EN;
      sync_q <= 1'b0;
    end else if (wr_en_i) begin
      en_q   <= wr_data_i[NPINS-1:0];
      sync_q <= wr_data_i[SYNC_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= RST_EN;
      shadow_q <= RST_EN;
      pend_q   <= 1'b0;
    end else if (wr_en_i && wr_mode == UPD_NOW) begin
      act_q  <= wr_data_i[NPINS-1:0];
      pend_q <= 1'b0;
    end else begin
      if (pend_q && period_start_i) begin
        act_q  <= shadow_q;
        pend_q <= 1'b0;
      end
      if (wr_en_i) begin
        shadow_q <= wr_data_i[NPINS-1:0];
        pend_q   <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data_o                = '0;
    rd_data_o[NPINS-1:0]     = en_q;
    rd_data_o[SYNC_BIT]      = sync_q;
  end

  assign act_o  = act_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/pwm_steer_shutdown.sv
module pwm_steer_shutdown
  import pwm_steer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shutdown_i,
  input  logic period_start_i,
  output logic sd_eff_o
);
  sd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (shutdown_i)          state_d = SD_HOLD;
    else if (period_start_i) state_d = SD_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SD_RUN;
    else         state_q <= state_d;
  end

  assign sd_eff_o = shutdown_i || (state_q == SD_HOLD);

endmodule

// File: rtl/pwm_steer_pinmux.sv
module pwm_steer_pinmux
  import pwm_steer_pkg::*;
#(
  parameter int unsigned NPINS = PIN_CNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] steer_i,
  input  logic [1:0]       pol_i,
  input  logic             pwm_i,
  input  logic             sd_eff_i,
  input  logic [NPINS-1:0] port_i,
  output logic [NPINS-1:0] pin_o
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic inv, mod_lvl, nxt, pin_q;

    assign inv     = pin_invert(g, pol_i);
    assign mod_lvl = sd_eff_i ? inv : (pwm_i ^ inv);
    assign nxt     = steer_i[g] ? mod_lvl : port_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pin_q <= 1'b0;
      else         pin_q <= nxt;
    end

    assign pin_o[g] = pin_q;
  end

endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_steer_pkg::*;
#(
  parameter int unsigned NPINS = PIN_CNT,
  parameter int unsigned REG_W = REG_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             single_mode_i,
  input  logic [1:0]       pol_i,
  input  logic             pwm_i,
  input  logic             period_start_i,
  input  logic             shutdown_i,
  input  logic [NPINS-1:0] port_i,
  output logic [NPINS-1:0] pin_o
);
  logic [NPINS-1:0] act_w, steer_w;
  logic             pend_w, sd_eff_w;

  pwm_steer_regs #(.NPINS(NPINS), .REG_W(REG_W)) i_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_en_i),
    .wr_data_i      (wr_data_i),
    .period_start_i (period_start_i),
    .rd_data_o      (rd_data_o),
    .act_o          (act_w),
    .pend_o         (pend_w)
  );

  pwm_steer_shutdown i_sd (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .shutdown_i     (shutdown_i),
    .period_start_i (period_start_i),
    .sd_eff_o       (sd_eff_w)
  );

  assign steer_w = single_mode_i ? act_w : '0;

  pwm_steer_pinmux #(.NPINS(NPINS)) i_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .steer_i  (steer_w),
    .pol_i    (pol_i),
    .pwm_i    (pwm_i),
    .sd_eff_i (sd_eff_w),
    .port_i   (port_i),
    .pin_o    (pin_o)
  );

endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk #(
  parameter int unsigned NPINS = 4,
  parameter int unsigned REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             single_mode_i,
  input logic [1:0]       pol_i,
  input logic             shutdown_i,
  input logic [NPINS-1:0] port_i,
  input logic [NPINS-1:0] pin_o,
  input logic [NPINS-1:0] act_w,
  input logic             pend_w,
  input logic             period_start_i
);
  always_comb begin
    if (rst_ni) AST_UPPER_ZERO: assert (rd_data_o[REG_W-1:NPINS+1] == '0); // R6
  end

  AST_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[NPINS:0] == $past(wr_data_i[NPINS:0])); // R6

  AST_IMMEDIATE_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[NPINS]) |=> act_w == $past(wr_data_i[NPINS-1:0])); // R4

  AST_DEFER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[NPINS] && !(pend_w && period_start_i)) |=> $stable(act_w)); // R5

  AST_MODE_OFF_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !single_mode_i |=> pin_o == $past(port_i)); // R9

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    localparam bit EVEN = (g % 2 == 0);
    AST_SD_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (single_mode_i && act_w[g] && shutdown_i)
        |=> pin_o[g] == $past(EVEN ? pol_i[1] : pol_i[0])); // R7
    AST_PORT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (single_mode_i && !act_w[g]) |=> pin_o[g] == $past(port_i[g])); // R2
  end

endmodule

bind pwm_steer pwm_steer_chk #(.NPINS(NPINS), .REG_W(REG_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .wr_data_i      (wr_data_i),
  .rd_data_o      (rd_data_o),
  .single_mode_i  (single_mode_i),
  .pol_i          (pol_i),
  .shutdown_i     (shutdown_i),
  .port_i         (port_i),
  .pin_o          (pin_o),
  .act_w          (act_w),
  .pend_w         (pend_w),
  .period_start_i (period_start_i)
);

// File: tb/test_pwm_steer.sv
`timescale 1ns/1ps
module test_pwm_steer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       single = 1'b1;
  logic [1:0] pol = '0;
  logic       pwm = 1'b0;
  logic       ps = 1'b0;
  logic       sd = 1'b0;
  logic [3:0] port = '0;
  logic [3:0] pin;

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R1";
  int lfsr = 32'h1ace;

  always #4 clk = ~clk;

  pwm_steer i_pwm_steer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .single_mode_i(single), .pol_i(pol), .pwm_i(pwm),
    .period_start_i(ps), .shutdown_i(sd), .port_i(port), .pin_o(pin)
  );

  // behavioural model
  int m_wr_en, m_wr_sync;       // written register
  int m_act, m_shadow, m_pend, m_hold, m_pin;

  function automatic int inv_of(int i, logic [1:0] p);
    if (i == 0 || i == 2) return p[1];
    return p[0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wr_en = 1; m_wr_sync = 0; m_act = 1; m_shadow = 1;
      m_pend = 0; m_hold = 0; m_pin = 0;
    end else begin
      int np;
      bit in_sd;
      np = 0;
      in_sd = sd || (m_hold != 0);
      for (int i = 0; i < 4; i++) begin
        int v;
        if (single && m_act[i]) v = in_sd ? inv_of(i, pol) : (pwm ^ inv_of(i, pol));
        else v = port[i];
        np |= v << i;
      end
      m_pin = np;
      if (sd) m_hold = 1;
      else if (ps) m_hold = 0;
      if (wr_en && !wr_data[4]) begin
        m_act = wr_data[3:0]; m_pend = 0;
      end else begin
        if (m_pend && ps) begin m_act = m_shadow; m_pend = 0; end
        if (wr_en) begin m_shadow = wr_data[3:0]; m_pend = 1; end
      end
      if (wr_en) begin m_wr_en = wr_data[3:0]; m_wr_sync = wr_data[4]; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (pin !== m_pin[3:0]) begin
        n_fail++;
        $display("FAIL %s pin_o act=%h exp=%h t=%0t", cur_req, pin, m_pin[3:0], $time);
      end
      n_tests++;
      if (rd_data !== {3'b0, m_wr_sync[0], m_wr_en[3:0]}) begin
        n_fail++;
        $display("FAIL %s rd_data_o act=%h exp=%h t=%0t", cur_req, rd_data,
                 {3'b0, m_wr_sync[0], m_wr_en[3:0]}, $time);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int rnd();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h8020_0003 : 0);
    return lfsr;
  endfunction

  // one cycle of random PWM and port activity
  task automatic tick(input bit strobe = 0);
    int r;
    @(negedge clk);
    r = rnd();
    pwm  = r[0];
    port = r[7:4];
    ps   = strobe;
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input bit strobe = 0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; ps = strobe; pwm = ~pwm;
  endtask

  initial begin
    #(8ns * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset read", rd_data, 8'h01);
    chk("R1 reset pins", {4'h0, pin}, 8'h00);
    cur_req = "R1";
    repeat (4) tick();

    cur_req = "R2";
    wr(8'h0F); repeat (8) tick();
    wr(8'h05); repeat (8) tick();
    wr(8'h0A); repeat (6) tick();

    cur_req = "R3";
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); pol = p[1:0];
      wr(8'h0F);
      repeat (6) tick();
    end
    pol = 2'b00;

    cur_req = "R4";
    wr(8'h13); tick(); wr(8'h0C); repeat (3) tick(1); repeat (3) tick();

    cur_req = "R5";
    wr(8'h13); repeat (4) tick(); tick(1); repeat (3) tick();
    wr(8'h18, 1'b1); repeat (3) tick(); tick(1); repeat (2) tick();
    // older pending applied at strobe while newer write waits
    wr(8'h12); tick(); wr(8'h14, 1'b1); repeat (2) tick(); tick(1); repeat (2) tick();

    cur_req = "R6";
    wr(8'hE6); tick();
    #1 chk("R6 readback", rd_data, 8'h06);
    repeat (2) tick();

    cur_req = "R7";
    @(negedge clk); pol = 2'b10;
    wr(8'h05);
    @(negedge clk); sd = 1'b1;
    repeat (6) tick();
    tick(1); // strobe during shutdown: must hold

    cur_req = "R8";
    @(negedge clk); sd = 1'b0;
    repeat (4) tick();
    wr(8'h1F); tick(1); repeat (4) tick();
    @(negedge clk); sd = 1'b1; tick(); @(negedge clk); sd = 1'b0; ps = 1'b1;
    repeat (3) tick();

    cur_req = "R9";
    @(negedge clk); single = 1'b0;
    wr(8'h0F); repeat (6) tick();
    @(negedge clk); sd = 1'b1; repeat (3) tick(); @(negedge clk); sd = 1'b0;
    tick(1);
    @(negedge clk); single = 1'b1;

    cur_req = "R10";
    for (int k = 0; k < 40; k++) begin
      int r;
      r = rnd();
      if (r[9:8] == 0) wr(r[23:16] & 8'h1F, r[10]);
      else tick(r[11] & r[12]);
      if (r[15:13] == 0) pol = r[25:24];
    end
    repeat (3) tick();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule